// File: doc/BRIEF.md
# Quad Double-Buffered Converter Code Register

This block is the digital front end of a four-channel digital-to-analog converter that is written over a parallel bus. Each channel has two register stages. The first is an input stage, selected by a two-bit channel address and loaded through an active-low write strobe. The second is an output stage whose contents are the code the converter sees. An active-low load strobe copies every input stage into its output stage in one step, so a host can stage new values one channel at a time and then update all four outputs together.

A shutdown input marks the converter as powered down. While it is powered down, the published codes read zero, but the stored contents survive. A synchronous reset clears every stage. Both strobes are sampled on the rising clock edge. A stage loads its source on every edge at which its strobe is low, so its output follows its source one cycle later.

The clean valid/ready style does not fit these pins, because the interface is strobe-driven and has no back-pressure. The block therefore keeps the plain strobe pins. It accepts one write and one load per clock cycle and never stalls.

Top module: `qdac_front`

## Requirements
- R1: When `rst` is high at a rising edge, every input stage, every output stage and `pwr_dn` are cleared to zero after that edge. This holds whatever the levels of `wr_n`, `ld_n` and `sd`.
- R2: At an edge with `wr_n` low, the input stage selected by `addr` takes `din`. The selection is 00 for channel A, 01 for B, 10 for C and 11 for D. The other three input stages keep their values. If `ld_n` is high, no output code changes.
- R3: At an edge with `ld_n` low, the output stage of every channel takes that channel's input-stage value, whatever the value of `addr`.
- R4: At an edge with both `wr_n` and `ld_n` low, the addressed channel's output stage takes `din` directly. Its new code therefore appears after a single edge. The other channels take their current input-stage values.
- R5: At an edge with both strobes high, every stage holds its value, and `din` and `addr` have no effect.
- R6: `pwr_dn` equals the level of `sd` sampled at the previous edge. While `pwr_dn` is high, all four codes read zero.
- R7: Writes and loads made while powered down still update the stages. After `pwr_dn` falls, the codes show the held output-stage contents, including any updates made during shutdown.
- R8: The data width `W` is 8, 10 or 12. `din[0]` maps to code bit 0, and `din[W-1]` maps to the code MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset; takes priority over all other inputs |
| wr_n | input | 1 | Active-low write strobe for the addressed input stage |
| ld_n | input | 1 | Active-low load strobe for all four output stages |
| addr | input | 2 | Channel select: 00 = A, 01 = B, 10 = C, 11 = D |
| din | input | W | Parallel data bus, bit 0 is the LSB |
| sd | input | 1 | Shutdown request, active high |
| code_a | output | W | Code of channel A (zero while powered down) |
| code_b | output | W | Code of channel B (zero while powered down) |
| code_c | output | W | Code of channel C (zero while powered down) |
| code_d | output | W | Code of channel D (zero while powered down) |
| pwr_dn | output | 1 | Powered-down flag |

## Verification
The properties assume that every input is a defined 0 or 1 at each rising edge. They also assume that reset is applied before the first check is due; they are disabled until the checker has seen one clock edge. The bench meets these assumptions by changing all inputs only on the falling edge and by starting with reset asserted. It also drives `addr` and `din` with meaningful values even when the strobes are high, so that the hold checks show those pins being ignored.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int CH_N = 4;
  localparam int ADDR_W = $clog2(CH_N);
  typedef enum logic [ADDR_W-1:0] {
    CH_A = 2'd0,
    CH_B = 2'd1,
    CH_C = 2'd2,
    CH_D = 2'd3
  } ch_e;
endpackage

// File: rtl/qdac_in_stage.sv
module qdac_in_stage #(
  parameter int W   = 12,
  parameter int SEL = 0,
  parameter int AW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  hold_q,
  output logic [W-1:0]  next_v
);
  logic hit;

  assign hit    = !wr_n && (addr == AW'(SEL));
  assign next_v = hit ? din : hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= next_v;
  end
endmodule

// File: rtl/qdac_dac_stage.sv
module qdac_dac_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!ld_n) q <= src;
  end
endmodule

// File: rtl/qdac_out_gate.sv
module qdac_out_gate #(
  parameter int W = 12
) (
  input  logic         pd,
  input  logic [W-1:0] held,
  output logic [W-1:0] code
);
  assign code = pd ? '0 : held;
endmodule

// File: rtl/qdac_front.sv
module qdac_front
  import qdac_pkg::*;
#(
  parameter int W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      din,
  input  logic              sd,
  output logic [W-1:0]      code_a,
  output logic [W-1:0]      code_b,
  output logic [W-1:0]      code_c,
  output logic [W-1:0]      code_d,
  output logic              pwr_dn
);
  logic [W-1:0] in_q   [CH_N];
  logic [W-1:0] in_nxt [CH_N];
  logic [W-1:0] dac_q  [CH_N];
  logic [W-1:0] code_v [CH_N];

  // The output stage sources the input stage's next value, so that write and
  // load together pass data through in a single edge.
  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    qdac_in_stage #(.W(W), .SEL(i), .AW(ADDR_W)) u_in (
      .clk(clk), .rst(rst), .wr_n(wr_n), .addr(addr), .din(din),
      .hold_q(in_q[i]), .next_v(in_nxt[i])
    );
    qdac_dac_stage #(.W(W)) u_dac (
      .clk(clk), .rst(rst), .ld_n(ld_n), .src(in_nxt[i]), .q(dac_q[i])
    );
    qdac_out_gate #(.W(W)) u_gate (
      .pd(pwr_dn), .held(dac_q[i]), .code(code_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pwr_dn <= 1'b0;
    else     pwr_dn <= sd;
  end

  assign code_a = code_v[CH_A];
  assign code_b = code_v[CH_B];
  assign code_c = code_v[CH_C];
  assign code_d = code_v[CH_D];
endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk
  import qdac_pkg::*;
#(
  parameter int W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_n,
  input logic              ld_n,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      din,
  input logic              sd,
  input logic              pwr_dn,
  input logic [W-1:0]      in_q  [CH_N],
  input logic [W-1:0]      dac_q [CH_N],
  input logic [W-1:0]      code_v[CH_N]
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  // R6
  pd_follow_chk: assert property (@(posedge clk) disable iff (rst || !started)
    !rst |=> pwr_dn == $past(sd));

  // R1
  rst_pd_chk: assert property (@(posedge clk) disable iff (!started)
    rst |=> !pwr_dn);

  for (genvar i = 0; i < CH_N; i++) begin : g_p
    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (!started)
      rst |=> (in_q[i] == '0) && (dac_q[i] == '0));

    // R2
    wr_hit_chk: assert property (@(posedge clk) disable iff (rst || !started)
      (!wr_n && addr == ADDR_W'(i)) |=> in_q[i] == $past(din));

    // R2
    wr_miss_chk: assert property (@(posedge clk) disable iff (rst || !started)
      (wr_n || addr != ADDR_W'(i)) |=> $stable(in_q[i]));

    // R3
    ld_copy_chk: assert property (@(posedge clk) disable iff (rst || !started)
      (!ld_n && (wr_n || addr != ADDR_W'(i))) |=> dac_q[i] == $past(in_q[i]));

    // R4
    ld_through_chk: assert property (@(posedge clk) disable iff (rst || !started)
      (!ld_n && !wr_n && addr == ADDR_W'(i)) |=> dac_q[i] == $past(din));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst || !started)
      (wr_n && ld_n) |=> $stable(dac_q[i]) && $stable(in_q[i]));

    // R6
    pd_zero_chk: assert property (@(posedge clk) disable iff (rst || !started)
      pwr_dn |-> code_v[i] == '0);

    // R7
    pd_resume_chk: assert property (@(posedge clk) disable iff (rst || !started)
      !pwr_dn |-> code_v[i] == dac_q[i]);
  end
endmodule

bind qdac_front qdac_front_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_n(wr_n), .ld_n(ld_n), .addr(addr), .din(din),
  .sd(sd), .pwr_dn(pwr_dn), .in_q(in_q), .dac_q(dac_q), .code_v(code_v)
);

// File: tb/qdac_front_tb.sv
`timescale 1ns/1ps
module qdac_front_tb;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst, wr_n, ld_n, sd;
  logic [1:0]   addr;
  logic [W-1:0] din;
  logic [W-1:0] code_a, code_b, code_c, code_d;
  logic         pwr_dn;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  qdac_front #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .ld_n(ld_n), .addr(addr), .din(din),
    .sd(sd), .code_a(code_a), .code_b(code_b), .code_c(code_c),
    .code_d(code_d), .pwr_dn(pwr_dn)
  );

  typedef struct packed {
    logic         rst, sd, wr_n, ld_n;
    logic [1:0]   a;
    logic [11:0]  d;
    logic [11:0]  e0, e1, e2, e3;
    logic         epd;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b1,1'b1,2'd0,12'h000, 12'h000,12'h000,12'h000,12'h000,1'b0,4'd1}, // R1
    '{1'b0,1'b0,1'b0,1'b1,2'd0,12'h123, 12'h000,12'h000,12'h000,12'h000,1'b0,4'd2}, // R2
    '{1'b0,1'b0,1'b0,1'b1,2'd1,12'h456, 12'h000,12'h000,12'h000,12'h000,1'b0,4'd2}, // R2
    '{1'b0,1'b0,1'b0,1'b1,2'd2,12'hABC, 12'h000,12'h000,12'h000,12'h000,1'b0,4'd2}, // R2
    '{1'b0,1'b0,1'b0,1'b1,2'd3,12'hFFF, 12'h000,12'h000,12'h000,12'h000,1'b0,4'd2}, // R2
    '{1'b0,1'b0,1'b1,1'b0,2'd2,12'h999, 12'h123,12'h456,12'hABC,12'hFFF,1'b0,4'd3}, // R3
    '{1'b0,1'b0,1'b1,1'b1,2'd2,12'h777, 12'h123,12'h456,12'hABC,12'hFFF,1'b0,4'd5}, // R5
    '{1'b0,1'b0,1'b0,1'b1,2'd2,12'h001, 12'h123,12'h456,12'hABC,12'hFFF,1'b0,4'd2}, // R2
    '{1'b0,1'b0,1'b0,1'b0,2'd1,12'h800, 12'h123,12'h800,12'h001,12'hFFF,1'b0,4'd4}, // R4
    '{1'b0,1'b1,1'b1,1'b1,2'd0,12'h000, 12'h000,12'h000,12'h000,12'h000,1'b1,4'd6}, // R6
    '{1'b0,1'b1,1'b0,1'b0,2'd0,12'h055, 12'h000,12'h000,12'h000,12'h000,1'b1,4'd7}, // R7
    '{1'b0,1'b0,1'b1,1'b1,2'd3,12'h321, 12'h055,12'h800,12'h001,12'hFFF,1'b0,4'd7}, // R7
    '{1'b1,1'b1,1'b0,1'b0,2'd3,12'hFFF, 12'h000,12'h000,12'h000,12'h000,1'b0,4'd1}, // R1
    '{1'b0,1'b0,1'b1,1'b0,2'd0,12'h5A5, 12'h000,12'h000,12'h000,12'h000,1'b0,4'd1}, // R1
    '{1'b0,1'b0,1'b0,1'b0,2'd3,12'h3C3, 12'h000,12'h000,12'h000,12'h3C3,1'b0,4'd4}  // R4
  };

  task automatic chk(input int req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic s, input logic w,
                      input logic l, input logic [1:0] a, input logic [W-1:0] d);
    rst = r; sd = s; wr_n = w; ld_n = l; addr = a; din = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] model [4];
    rst = 1'b1; sd = 1'b0; wr_n = 1'b1; ld_n = 1'b1; addr = '0; din = '0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].rst, TBL[i].sd, TBL[i].wr_n, TBL[i].ld_n, TBL[i].a, TBL[i].d);
      chk(int'(TBL[i].req), $sformatf("vec%0d code_a", i), code_a, TBL[i].e0);
      chk(int'(TBL[i].req), $sformatf("vec%0d code_b", i), code_b, TBL[i].e1);
      chk(int'(TBL[i].req), $sformatf("vec%0d code_c", i), code_c, TBL[i].e2);
      chk(int'(TBL[i].req), $sformatf("vec%0d code_d", i), code_d, TBL[i].e3);
      chk(int'(TBL[i].req), $sformatf("vec%0d pwr_dn", i),
          W'(pwr_dn), W'(TBL[i].epd));
    end

    // R2 decode sweep with R4 pass-through, one channel per cycle
    step(1'b1, 1'b0, 1'b1, 1'b1, 2'd0, '0);
    for (int k = 0; k < 4; k++) model[k] = '0;
    for (int a = 0; a < 4; a++) begin
      logic [W-1:0] v;
      v = W'((a + 1) * 12'h111);
      model[a] = v;
      step(1'b0, 1'b0, 1'b0, 1'b0, 2'(a), v);
      chk(2, $sformatf("sweep%0d code_a", a), code_a, model[0]);
      chk(2, $sformatf("sweep%0d code_b", a), code_b, model[1]);
      chk(2, $sformatf("sweep%0d code_c", a), code_c, model[2]);
      chk(2, $sformatf("sweep%0d code_d", a), code_d, model[3]);
    end

    // R8 bit positions: MSB alone, then LSB alone
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, W'(1) << (W - 1));
    chk(8, "msb position", W'(code_a[W-1]), W'(1));
    chk(8, "msb only", code_a, W'(1) << (W - 1));
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, W'(1));
    chk(8, "lsb position", W'(code_a[0]), W'(1));

    // R3 load ignores addr: stage B only, then load with addr pointing at D
    step(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 12'hE0E);
    chk(2, "staged b not visible", code_b, 12'h222);
    step(1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 12'h000);
    chk(3, "load b any addr", code_b, 12'hE0E);
    chk(3, "load d unchanged", code_d, 12'h444);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule